// File: doc/BRIEF.md
# Four-Lane Scaled Float-to-Fixed Saturating Converter

This block takes a 128-bit vector that holds four IEEE-754 single-precision values. It converts each one into a signed 32-bit integer. Before conversion, every lane is multiplied by a power of two, 2^S, where S is a 5-bit unsigned scale. This turns float channels into fixed-point values in one step. For example, with S = 15, an input of 1.0 becomes 32768.

The scaled value is truncated toward zero and clamped to the signed 32-bit range. A lane that clamps, or that holds a NaN, raises saturation. The four lane flags are ORed into a per-operation saturation output. That output also sets a sticky status bit, which only an explicit clear input resets.

Results are registered. They appear one cycle after the input is accepted, with a valid strobe. A flush-denormal mode bit makes denormal inputs count as zero before scaling.

Top module: `vfix_cvt`

## Requirements
- R1: Lane i of `in_vec` (bits 32i+31 down to 32i, float32 layout: sign bit 31, biased exponent bits 30:23 with bias 127, fraction bits 22:0) produces lane i of `out_vec` (same bit range). Lanes do not affect each other.
- R2: For finite inputs whose scaled value lies in [-2^31, 2^31), the lane result equals the value times 2^`in_scale`, truncated toward zero, and raises no saturation.
- R3: Positive infinity, and any positive value whose scaled magnitude is 2^31 or more, gives 0x7FFFFFFF with saturation.
- R4: Negative infinity, and any value whose scaled value is below -2^31, gives 0x80000000 with saturation. A scaled value of exactly -2^31 gives 0x80000000 without saturation.
- R5: A NaN lane (exponent all ones, nonzero fraction) gives 0 and raises saturation.
- R6: Zeros of either sign and denormal inputs give 0 without saturation, whatever the value of `in_flush_dn`.
- R7: When `in_valid` is high at a clock edge, `out_vec` and `out_sat` show that operation's results after that edge, and `out_valid` is high for exactly that cycle. `out_sat` is the OR of the four lane saturation flags. Without `in_valid`, `out_vec` and `out_sat` hold their values.
- R8: `sat_sticky` becomes 1 at the same edge that an operation with saturation is captured. It stays 1 until `sat_clr` is sampled high. If a clear and a saturating operation meet at the same edge, the sticky bit ends up 1.
- R9: After reset, `out_valid`, `out_sat` and `sat_sticky` are 0 and `out_vec` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept an operation at this edge |
| in_vec | input | 128 | Four float32 lanes |
| in_scale | input | 5 | Power-of-two pre-scale S |
| in_flush_dn | input | 1 | Treat denormal inputs as zero |
| sat_clr | input | 1 | Clear the sticky saturation bit |
| out_valid | output | 1 | Result valid this cycle |
| out_vec | output | 128 | Four signed 32-bit results |
| out_sat | output | 1 | Saturation of the last captured operation |
| sat_sticky | output | 1 | Sticky saturation status |

## Verification
The hardest case to reach from the ports is the boundary at scaled magnitude 2^31. There, a negative lane with a zero fraction must pass through without saturation, while every neighbouring value must clamp. Random fractions almost never hit it. The stimulus therefore combines directed lanes with exponents that, after scaling, land exactly on 2^31 and one step to either side. Random operands use exponents drawn from a window around the saturation threshold, so both the shifting path and the clamping path are exercised often. The sticky bit is also driven with a clear in the same cycle as a saturating operation.

// File: rtl/vfix_pkg.sv
package vfix_pkg;
  localparam int LANES = 4;
  localparam int IW    = 32;
  localparam int EXPW  = 8;
  localparam int MANW  = 23;
  localparam int SIGW  = MANW + 1;
  localparam int BIAS  = 127;
  localparam int SCW   = 5;
  localparam int VW    = LANES * IW;
  // binary point sits MANW bits into the significand
  localparam int KOFF  = BIAS + MANW;
  // shift at which the magnitude first reaches 2^(IW-1)
  localparam int KMAX  = IW - SIGW;

  typedef struct packed {
    logic            sgn;
    logic [EXPW-1:0] exp;
    logic [MANW-1:0] man;
  } f32_t;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_FIN  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fcls_t;
endpackage

// File: rtl/vfix_lane.sv
module vfix_lane
  import vfix_pkg::*;
(
  input  logic [IW-1:0]  lane_in,
  input  logic [SCW-1:0] scale,
  input  logic           flush_dn,
  output logic [IW-1:0]  lane_out,
  output logic           lane_sat
);
  localparam int KW = EXPW + 3;

  f32_t                 f;
  fcls_t                cls;
  logic [SIGW-1:0]      sig;
  logic [EXPW-1:0]      exp_eff;
  logic signed [KW-1:0] k;
  logic signed [KW-1:0] nk;
  logic [IW-1:0]        sig_ext;
  logic [IW-1:0]        mag;
  logic [IW-1:0]        min_neg;
  logic [IW-1:0]        max_pos;

  assign f       = f32_t'(lane_in);
  assign min_neg = {1'b1, {(IW-1){1'b0}}};
  assign max_pos = {1'b0, {(IW-1){1'b1}}};

  always_comb begin
    if (f.exp == {EXPW{1'b1}})
      cls = (f.man != '0) ? CLS_NAN : CLS_INF;
    else if (f.exp == '0 && (f.man == '0 || flush_dn))
      cls = CLS_ZERO;
    else
      cls = CLS_FIN;
  end

  // denormals keep exponent 1 and drop the hidden bit
  assign exp_eff = (f.exp == '0) ? EXPW'(1) : f.exp;
  assign sig     = {(f.exp != '0), f.man};
  assign sig_ext = IW'(sig);
  // scale folded into the exponent: no multiplier
  assign k  = signed'(KW'(exp_eff)) + signed'(KW'(scale)) - signed'(KW'(KOFF));
  assign nk = -k;

  always_comb begin
    mag = '0;
    if (k >= 0 && k < KMAX)
      mag = sig_ext << k[4:0];
    else if (k < 0 && nk < SIGW)
      mag = sig_ext >> nk[4:0];
  end

  always_comb begin
    lane_out = '0;
    lane_sat = 1'b0;
    unique case (cls)
      CLS_ZERO: begin
        lane_out = '0;
      end
      CLS_NAN: begin
        lane_out = '0;
        lane_sat = 1'b1;
      end
      CLS_INF: begin
        lane_out = f.sgn ? min_neg : max_pos;
        lane_sat = 1'b1;
      end
      default: begin
        if (k > KMAX || (k == KMAX && !(f.sgn && f.man == '0 && f.exp != '0))) begin
          lane_out = f.sgn ? min_neg : max_pos;
          lane_sat = 1'b1;
        end else if (k == KMAX) begin
          lane_out = min_neg;
        end else begin
          lane_out = f.sgn ? (~mag + IW'(1)) : mag;
        end
      end
    endcase
  end
endmodule

// File: rtl/vfix_sticky.sv
module vfix_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_d;
  logic flag_q;

  always_comb begin
    flag_d = flag_q;
    if (set_i)
      flag_d = 1'b1;
    else if (clr_i)
      flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else
      flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/vfix_cvt.sv
module vfix_cvt
  import vfix_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [VW-1:0]  in_vec,
  input  logic [SCW-1:0] in_scale,
  input  logic           in_flush_dn,
  input  logic           sat_clr,
  output logic           out_valid,
  output logic [VW-1:0]  out_vec,
  output logic           out_sat,
  output logic           sat_sticky
);
  logic [VW-1:0]    lane_res;
  logic [LANES-1:0] lane_sat;
  logic             sat_any;
  logic             valid_d, valid_q;
  logic [VW-1:0]    vec_d, vec_q;
  logic             sat_d, sat_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vfix_lane u_lane (
      .lane_in  (in_vec[g*IW +: IW]),
      .scale    (in_scale),
      .flush_dn (in_flush_dn),
      .lane_out (lane_res[g*IW +: IW]),
      .lane_sat (lane_sat[g])
    );
  end

  assign sat_any = |lane_sat;

  always_comb begin
    valid_d = in_valid;
    vec_d   = vec_q;
    sat_d   = sat_q;
    if (in_valid) begin
      vec_d = lane_res;
      sat_d = sat_any;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
      sat_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      vec_q   <= vec_d;
      sat_q   <= sat_d;
    end
  end

  vfix_sticky u_sticky (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (in_valid & sat_any),
    .clr_i  (sat_clr),
    .flag_o (sat_sticky)
  );

  assign out_valid = valid_q;
  assign out_vec   = vec_q;
  assign out_sat   = sat_q;
endmodule

// File: rtl/vfix_cvt_chk.sv
module vfix_cvt_chk
  import vfix_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          sat_clr,
  input logic          sat_any,
  input logic          out_valid,
  input logic [VW-1:0] out_vec,
  input logic          out_sat,
  input logic          sat_sticky
);
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r7_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r7_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_vec) && $stable(out_sat)));
  a_r8_sat_sets_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sat) |-> sat_sticky);
  a_r8_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_sticky && !sat_clr) |=> sat_sticky);
  a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_clr && !(in_valid && sat_any)) |=> !sat_sticky);
endmodule

bind vfix_cvt vfix_cvt_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .sat_clr    (sat_clr),
  .sat_any    (sat_any),
  .out_valid  (out_valid),
  .out_vec    (out_vec),
  .out_sat    (out_sat),
  .sat_sticky (sat_sticky)
);

// File: tb/vfix_cvt_tb.sv
module vfix_cvt_tb;
  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] in_vec;
  logic [4:0]   in_scale;
  logic         in_flush_dn;
  logic         sat_clr;
  logic         out_valid;
  logic [127:0] out_vec;
  logic         out_sat;
  logic         sat_sticky;

  int checks;
  int failures;
  bit exp_sticky;

  vfix_cvt u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
    .in_scale(in_scale), .in_flush_dn(in_flush_dn), .sat_clr(sat_clr),
    .out_valid(out_valid), .out_vec(out_vec), .out_sat(out_sat),
    .sat_sticky(sat_sticky)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // Reference model from the requirements, using real arithmetic
  function automatic void ref_lane(input logic [31:0] b, input int s,
                                   output logic [31:0] r, output bit sat);
    int  e;
    int  m;
    real v;
    e = int'(b[30:23]);
    m = int'(b[22:0]);
    sat = 1'b0;
    if (e == 255 && m != 0) begin
      r = 32'h0; sat = 1'b1;                           // R5
    end else if (e == 255) begin
      r = b[31] ? 32'h80000000 : 32'h7FFFFFFF; sat = 1'b1;   // R3 R4
    end else begin
      if (e == 0) v = real'(m) * (2.0 ** (s - 149));   // R6
      else        v = real'(m + 8388608) * (2.0 ** (e - 150 + s));
      if (b[31]) v = -v;
      if (v >= 2147483648.0) begin
        r = 32'h7FFFFFFF; sat = 1'b1;
      end else if (v < -2147483648.0) begin
        r = 32'h80000000; sat = 1'b1;
      end else begin
        r = 32'($rtoi(v));                              // R2 truncation
      end
    end
  endfunction

  task automatic run_op(input logic [127:0] v, input logic [4:0] s,
                        input bit fl, input bit clr, input string tag);
    logic [127:0] exp_v;
    bit           exp_s;
    exp_s = 1'b0;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] r;
      bit          ls;
      ref_lane(v[i*32 +: 32], int'(s), r, ls);
      exp_v[i*32 +: 32] = r;
      exp_s |= ls;
    end
    @(negedge clk);
    in_valid = 1'b1; in_vec = v; in_scale = s; in_flush_dn = fl; sat_clr = clr;
    @(negedge clk);
    in_valid = 1'b0; sat_clr = 1'b0;
    if (exp_s) exp_sticky = 1'b1;
    else if (clr) exp_sticky = 1'b0;
    checks++;
    if (out_vec !== exp_v || out_sat !== exp_s || out_valid !== 1'b1) begin
      failures++;
      $display("FAIL %s vec=%h sat=%0b vld=%0b expected vec=%h sat=%0b vld=1",
               tag, out_vec, out_sat, out_valid, exp_v, exp_s);
    end
    checks++;
    if (sat_sticky !== exp_sticky) begin
      failures++;
      $display("FAIL R8 sticky=%0b expected %0b (%s)", sat_sticky, exp_sticky, tag);
    end
  endtask

  task automatic check_idle(input logic [127:0] prev_v, input bit prev_s);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_vec !== prev_v || out_sat !== prev_s) begin
      failures++;
      $display("FAIL R7 idle vld=%0b vec=%h sat=%0b expected vld=0 vec=%h sat=%0b",
               out_valid, out_vec, out_sat, prev_v, prev_s);
    end
  endtask

  task automatic clear_only();
    @(negedge clk);
    sat_clr = 1'b1;
    @(negedge clk);
    sat_clr = 1'b0;
    exp_sticky = 1'b0;
    checks++;
    if (sat_sticky !== 1'b0) begin
      failures++;
      $display("FAIL R8 clear sticky=%0b expected 0", sat_sticky);
    end
  endtask

  function automatic logic [31:0] rnd_float();
    logic [31:0] f;
    int          pick;
    pick = int'($urandom % 16);
    f[31]    = $urandom % 2;
    f[22:0]  = 23'($urandom);
    if (pick == 0)      f[30:23] = 8'd255;
    else if (pick == 1) f[30:23] = 8'd0;
    else                f[30:23] = 8'(100 + $urandom % 80);
    return f;
  endfunction

  initial begin
    logic [127:0] hold_v;
    bit           hold_s;
    void'($urandom(32'd20240611));
    checks = 0; failures = 0; exp_sticky = 1'b0;
    in_valid = 0; in_vec = '0; in_scale = '0; in_flush_dn = 0; sat_clr = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 0 || out_vec !== '0 || out_sat !== 0 || sat_stkchk()) begin
      failures++;
      $display("FAIL R9 reset vld=%0b vec=%h sat=%0b sticky=%0b expected all zero",
               out_valid, out_vec, out_sat, sat_sticky);
    end
    rst_n = 1'b1;

    // R2: 1.0 and 0.5 with S=15, -1.5 truncates to -1, 3.75 to 3
    run_op({32'h3F800000, 32'h3F000000, 32'hBFC00000, 32'h40700000}, 5'd15, 0, 0, "R2 scale15");
    run_op({32'h3F800000, 32'h3F000000, 32'hBFC00000, 32'h40700000}, 5'd0, 0, 0, "R2 trunc");
    // R1: lanes independent, one NaN does not disturb others
    run_op({32'h3F800000, 32'h7FC00000, 32'h3F800000, 32'h40000000}, 5'd3, 0, 0, "R1 R5 lanes");
    // R4: exact -2^31 is not saturation
    run_op({32'hCF000000, 32'h00000000, 32'h80000000, 32'h3F800000}, 5'd0, 0, 1, "R4 exact min");
    run_op({32'hBF800000, 32'h0, 32'h0, 32'h0}, 5'd31, 0, 0, "R4 -1 scale31");
    // R3: 2^31 saturates, 2^31-ish minus one step does not
    run_op({32'h4F000000, 32'h4EFFFFFF, 32'h3F800000, 32'h0}, 5'd0, 0, 0, "R3 boundary");
    run_op({32'h3F800000, 32'h0, 32'h0, 32'h0}, 5'd31, 0, 0, "R3 1.0 scale31");
    // R4: just below -2^31 and -inf
    run_op({32'hCF000001, 32'hFF800000, 32'h0, 32'h0}, 5'd0, 0, 0, "R4 below min");
    run_op({32'h7F800000, 32'h0, 32'h0, 32'h0}, 5'd7, 0, 0, "R3 +inf");
    // R6: denormals in both modes, signed zero
    run_op({32'h007FFFFF, 32'h80000001, 32'h80000000, 32'h00400000}, 5'd31, 0, 0, "R6 denorm nj0");
    run_op({32'h007FFFFF, 32'h80000001, 32'h80000000, 32'h00400000}, 5'd31, 1, 0, "R6 denorm nj1");
    // R8: clear in same cycle as saturating op keeps sticky
    run_op({32'h7FC00000, 32'h0, 32'h0, 32'h0}, 5'd0, 0, 1, "R8 set wins");
    hold_v = out_vec; hold_s = out_sat;
    check_idle(hold_v, hold_s);
    check_idle(hold_v, hold_s);
    clear_only();
    run_op({32'h3F800000, 32'h0, 32'h0, 32'h0}, 5'd1, 0, 0, "R8 stays clear");

    for (int n = 0; n < 400; n++) begin
      logic [127:0] v;
      for (int i = 0; i < 4; i++) v[i*32 +: 32] = rnd_float();
      run_op(v, 5'($urandom), bit'($urandom % 2), ($urandom % 8) == 0, "R1 R2 R3 R4 random");
      if (n % 50 == 0) begin
        hold_v = out_vec; hold_s = out_sat;
        check_idle(hold_v, hold_s);
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic bit sat_stkchk();
    return sat_sticky !== 1'b0;
  endfunction
endmodule